// File: doc/BRIEF.md
# SIMD Shift-Right-and-Insert Unit

This block executes a vector shift-right-and-insert operation on a 64-bit or 128-bit operand. It takes a 32-bit instruction word, the source operand and the current destination operand. From one shared 4-bit immediate it works out the lane width and the shift amount. Every source lane is shifted right logically, and the shifted bits are merged into the matching destination lane. The destination's upper bits, where zeros would otherwise have entered, keep their old value.

The result is registered, so there is exactly one cycle of latency, and that latency does not depend on the data. A flag marks encodings that are undefined. A second flag marks instruction words that are not this operation at all. A surrounding pipeline uses both flags to raise its own exception or to take a different decode path. The register file, the privilege checks and the fetch path are left to the surrounding logic.

Top module: `simd_sri_unit`

## Requirements
- R1: The word is recognised only when bit 31 is 0, bit 29 is 1, bits 27:24 are 1111, bit 23 is 0, bits 15:10 are 010001, and either bit 28 is 0 (vector form) or bits 28 and 30 are both 1 (scalar form). Any other word raises `out_nodec` with a zero result.
- R2: In the vector form, the lane width is 8 shifted left by the index of the highest set bit of the immediate high nibble (bits 22:19). This gives 8, 16, 32 or 64-bit lanes.
- R3: The shift amount is twice the lane width minus the unsigned 7-bit value {bits 22:19, bits 18:16}, which lies between 1 and the lane width.
- R4: In the vector form, bit 30 set selects a 128-bit operation and bit 30 clear selects a 64-bit operation. The lane count is the operation width divided by the lane width.
- R5: A vector word with bit 22 set and bit 30 clear raises `out_undef` with a zero result.
- R6: A vector word with bits 22:19 all zero raises `out_nodec` with a zero result.
- R7: The scalar form always uses one 64-bit lane and a 64-bit operation. If bit 22 is clear, it raises `out_undef` with a zero result.
- R8: In each lane, the result is (old destination AND NOT mask) OR (source shifted right), where the mask is all-ones shifted right by the shift amount. Source bits shifted past bit 0 are discarded.
- R9: For a 64-bit operation, result bits 127:64 are zero.
- R10: `out_valid` equals `in_valid` of the previous cycle for every data value. When `out_valid` is low, all outputs are zero.
- R11: A shift equal to the lane width returns the destination lane unchanged.
- R12: After reset all outputs are zero. `out_undef` and `out_nodec` are never high together, and each implies `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| instr | input | 32 | Instruction word |
| src_opnd | input | 128 | Source operand |
| dst_opnd | input | 128 | Current destination operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 128 | Merged result |
| out_undef | output | 1 | Undefined encoding |
| out_nodec | output | 1 | Word is not this operation |

## Verification
A wrong lane-width or shift decode would show up as a shifted or misplaced bit field in `out_result` one cycle after the word is presented. A broken mask would show up the same way, as bits lost or kept at the lane's upper edge. The bench sweeps every value of the immediate against both operation widths and both forms, using data patterns that make each bit position visible. This means a decode fault is exposed on the first affected word. A stuck result register would show as stale data or a stale flag on the following idle cycle.

// File: rtl/sri_pkg.sv
package sri_pkg;
    localparam int DATA_W   = 128;
    localparam int HALF_W   = DATA_W / 2;
    localparam int MIN_LANE = 8;
    localparam int NSIZES   = 4;
    localparam int IDX_W    = $clog2(NSIZES);
    localparam int SH_W     = 7;

    typedef struct packed {
        logic              valid;
        logic              undef;
        logic              nodec;
        logic [DATA_W-1:0] result;
    } sri_out_t;
endpackage

// File: rtl/sri_decode.sv
module sri_decode
    import sri_pkg::*;
(
    input  logic [31:10]     word,
    output logic [IDX_W-1:0] size_idx,
    output logic [SH_W-1:0]  shamt,
    output logic             wide,
    output logic             undef,
    output logic             nodec
);
    logic       common_ok;
    logic       scalar;
    logic [3:0] hi_nib;
    logic [6:0] imm7;
    logic [7:0] twice_w;
    logic [7:0] diff;

    always_comb begin
        hi_nib    = word[22:19];
        imm7      = word[22:16];
        scalar    = word[28];
        common_ok = !word[31] && word[29] && (word[27:24] == 4'b1111) && !word[23]
                    && (word[15:10] == 6'b010001);
        nodec     = !common_ok || (scalar && !word[30]) || (!scalar && hi_nib == 4'd0);
        undef     = !nodec && (scalar ? !hi_nib[3] : (hi_nib[3] && !word[30]));

        if (scalar || hi_nib[3])   size_idx = IDX_W'(3);
        else if (hi_nib[2])        size_idx = IDX_W'(2);
        else if (hi_nib[1])        size_idx = IDX_W'(1);
        else                       size_idx = IDX_W'(0);

        twice_w = 8'(2 * MIN_LANE) << size_idx;
        diff    = twice_w - {1'b0, imm7};
        shamt   = diff[SH_W-1:0];
        wide    = word[30] && !scalar;
    end
endmodule

// File: rtl/sri_lane.sv
module sri_lane #(
    parameter int W    = 8,
    parameter int SH_W = 7
) (
    input  logic [W-1:0]    src_lane,
    input  logic [W-1:0]    dst_lane,
    input  logic [SH_W-1:0] shamt,
    output logic [W-1:0]    res_lane
);
    logic [W-1:0] keep_mask;
    logic [W-1:0] moved;

    always_comb begin
        keep_mask = {W{1'b1}} >> shamt;
        moved     = src_lane >> shamt;
        res_lane  = (dst_lane & ~keep_mask) | moved;
    end
endmodule

// File: rtl/simd_sri_unit.sv
module simd_sri_unit
    import sri_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] src_opnd,
    input  logic [DATA_W-1:0] dst_opnd,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_undef,
    output logic              out_nodec
);
    logic [IDX_W-1:0]  size_idx;
    logic [SH_W-1:0]   shamt;
    logic              wide;
    logic              dec_undef;
    logic              dec_nodec;
    logic              unused_regs;
    logic [DATA_W-1:0] by_size [NSIZES];
    sri_out_t          state_d, state_q;

    assign unused_regs = ^instr[9:0];

    sri_decode dec_i (
        .word     (instr[31:10]),
        .size_idx (size_idx),
        .shamt    (shamt),
        .wide     (wide),
        .undef    (dec_undef),
        .nodec    (dec_nodec)
    );

    for (genvar g = 0; g < NSIZES; g++) begin : g_size
        localparam int LW = MIN_LANE << g;
        localparam int NL = DATA_W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            sri_lane #(.W(LW), .SH_W(SH_W)) lane_i (
                .src_lane (src_opnd[l*LW +: LW]),
                .dst_lane (dst_opnd[l*LW +: LW]),
                .shamt    (shamt),
                .res_lane (by_size[g][l*LW +: LW])
            );
        end
    end

    always_comb begin
        state_d = '0;
        if (in_valid) begin
            state_d.valid = 1'b1;
            state_d.undef = dec_undef;
            state_d.nodec = dec_nodec;
            if (!dec_undef && !dec_nodec) begin
                state_d.result = by_size[size_idx];
                if (!wide) state_d.result[DATA_W-1:HALF_W] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid  = state_q.valid;
    assign out_undef  = state_q.undef;
    assign out_nodec  = state_q.nodec;
    assign out_result = state_q.result;
endmodule

// File: rtl/sri_unit_chk.sv
module sri_unit_chk
    import sri_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [31:0]       instr,
    input logic [DATA_W-1:0] out_result,
    input logic              out_valid,
    input logic              out_undef,
    input logic              out_nodec
);
    logic shape_ok;
    assign shape_ok = !instr[31] && instr[29] && (instr[27:24] == 4'b1111) && !instr[23]
                      && (instr[15:10] == 6'b010001);

    p_valid_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && out_result == '0));
    p_vec_undef_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shape_ok && !instr[28] && instr[22] && !instr[30]) |=> out_undef);
    p_vec_zero_nib_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shape_ok && !instr[28] && instr[22:19] == 4'd0) |=> out_nodec);
    p_scalar_undef_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shape_ok && instr[28] && instr[30] && !instr[22]) |=> out_undef);
    p_bad_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !shape_ok) |=> out_nodec);
    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !instr[30]) |=> out_result[DATA_W-1:HALF_W] == '0);
    p_flags_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_undef && out_nodec));
    p_flag_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_undef || out_nodec) |-> (out_valid && out_result == '0));
endmodule

bind simd_sri_unit sri_unit_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .instr      (instr),
    .out_result (out_result),
    .out_valid  (out_valid),
    .out_undef  (out_undef),
    .out_nodec  (out_nodec)
);

// File: tb/simd_sri_unit_tb_top.sv
module simd_sri_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] src_opnd = '0;
    logic [127:0] dst_opnd = '0;
    logic         out_valid;
    logic [127:0] out_result;
    logic         out_undef;
    logic         out_nodec;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    simd_sri_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_opnd(src_opnd), .dst_opnd(dst_opnd), .out_valid(out_valid),
        .out_result(out_result), .out_undef(out_undef), .out_nodec(out_nodec)
    );

    function automatic logic [31:0] vec_word(input logic q, input logic [3:0] hn, input logic [2:0] lb);
        return {1'b0, q, 1'b1, 6'b011110, hn, lb, 6'b010001, 5'd3, 5'd7};
    endfunction

    function automatic logic [31:0] scl_word(input logic [3:0] hn, input logic [2:0] lb);
        return {1'b0, 1'b1, 1'b1, 6'b111110, hn, lb, 6'b010001, 5'd9, 5'd1};
    endfunction

    function automatic void model(input logic [31:0] w, input logic [127:0] s, input logic [127:0] d,
                                  output logic [127:0] r, output logic u, output logic n);
        logic ok, sc, q;
        logic [3:0] hn;
        int es, sh, width;
        ok = !w[31] && w[29] && (w[27:24] == 4'b1111) && !w[23] && (w[15:10] == 6'b010001);
        sc = w[28]; q = w[30]; hn = w[22:19];
        r = '0; u = 1'b0; n = 1'b0;
        if (!ok || (sc && !q) || (!sc && hn == 4'd0)) n = 1'b1;
        else if (sc ? !hn[3] : (hn[3] && !q)) u = 1'b1;
        else begin
            es = sc ? 64 : (hn[3] ? 64 : hn[2] ? 32 : hn[1] ? 16 : 8);
            sh = 2 * es - int'(w[22:16]);
            width = (sc || !q) ? 64 : 128;
            for (int i = 0; i < width; i++) begin
                int b = i % es;
                if (b + sh >= es) r[i] = d[i];
                else r[i] = s[i - b + b + sh];
            end
        end
    endfunction

    task automatic check(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] w, input logic [127:0] s, input logic [127:0] d, input string tag);
        logic [127:0] er;
        logic eu, en;
        model(w, s, d, er, eu, en);
        @(negedge clk);
        in_valid = 1'b1; instr = w; src_opnd = s; dst_opnd = d;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, "result", out_result, er);
        check(tag, "flags", {125'd0, out_valid, out_undef, out_nodec}, {125'd0, 1'b1, eu, en});
    endtask

    function automatic string pick_tag(input logic q, input logic [3:0] hn, input logic [2:0] lb);
        int es, sh;
        es = hn[3] ? 64 : hn[2] ? 32 : hn[1] ? 16 : 8;
        sh = 2 * es - int'({hn, lb});
        if (hn == 4'd0) return "R6";
        if (hn[3] && !q) return "R5";
        if (sh == es) return "R11";
        if (!q) return (hn[0] ? "R9" : "R2");
        return (lb == 3'd0) ? "R4" : "R3";
    endfunction

    initial begin
        logic [127:0] pats [4];
        pats[0] = {4{32'hA5C3_96F1}};
        pats[1] = {$urandom, $urandom, $urandom, $urandom};
        pats[2] = {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210};
        pats[3] = {$urandom, $urandom, $urandom, $urandom};

        // R12: reset state
        #12;
        check("R12", "reset", {out_result, out_valid, out_undef, out_nodec}, '0);
        @(negedge clk); rst_n = 1'b1;

        // R2 R3 R4 R5 R6 R9 R11: full vector sweep
        for (int q = 0; q < 2; q++)
            for (int hn = 0; hn < 16; hn++)
                for (int lb = 0; lb < 8; lb++)
                    for (int p = 0; p < 2; p++)
                        run_op(vec_word(q[0], hn[3:0], lb[2:0]), pats[p], pats[p+2],
                               pick_tag(q[0], hn[3:0], lb[2:0]));

        // R7: scalar sweep
        for (int hn = 0; hn < 16; hn++)
            for (int lb = 0; lb < 8; lb++)
                run_op(scl_word(hn[3:0], lb[2:0]), pats[1], pats[2], "R7");

        // R8: all-ones source into zero destination, and the reverse
        run_op(vec_word(1'b1, 4'b0001, 3'd5), '1, '0, "R8");
        run_op(vec_word(1'b1, 4'b0100, 3'd1), '0, '1, "R8");
        run_op(vec_word(1'b1, 4'b1000, 3'd7), {64'h8000_0000_0000_0001, 64'h1}, '0, "R8");

        // R1: damaged fixed fields
        run_op(vec_word(1'b1, 4'b0010, 3'd0) | 32'h8000_0000, pats[0], pats[1], "R1");
        run_op(vec_word(1'b1, 4'b0010, 3'd0) ^ 32'h0000_2000, pats[0], pats[1], "R1");
        run_op(vec_word(1'b1, 4'b0010, 3'd0) | 32'h0080_0000, pats[0], pats[1], "R1");
        run_op(scl_word(4'b1000, 3'd0) & ~32'h4000_0000, pats[0], pats[1], "R1");

        // R10: idle cycle after an operation
        @(negedge clk);
        check("R10", "idle", {out_result, out_valid, out_undef, out_nodec}, '0);

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule